// File: doc/BRIEF.md
# Two-Write-Port RAM Built from XOR-Encoded Banks

This block is a small memory that accepts two independent writes in every clock cycle. Its storage cells each have only one write port. Write port 0 owns bank 0 and write port 1 owns bank 1, and neither port ever stores into the other's bank. A write does not store its data as it is. It stores the data XORed with the value the opposite bank holds at the same address. Any read then XORs the two banks at the read address, and the two contributions from the other bank cancel. The result is the value most recently written to that location, whichever port wrote it.

Each lookup of the opposite bank is registered, so a write commits into its own bank one cycle after it is requested. Bypass paths hide this delay. A write that lands right after an opposite-port write to the same address picks up the value in flight. A read that follows a write by one cycle also sees the new value. Any number of synchronous read ports may be configured, and each has one clock of latency. When both ports write the same address in the same cycle, the result is undefined.

Top module: `xor_dual_write_ram`

## Requirements
- R1: After reset every location reads as zero.
- R2: Read data for an address presented in cycle t appears on that read port's data output after the clock edge that ends cycle t, and holds for cycle t+1.
- R3: Data written through port 0 is returned by a later read of that address.
- R4: Data written through port 1 is returned by a later read of that address.
- R5: Both ports may write different addresses in the same cycle, and both values are kept.
- R6: When the two ports write one address in consecutive cycles, a read returns the value written last.
- R7: A read issued in the same cycle as a write to that address returns the value stored before that write.
- R8: A read issued in the cycle right after a write returns the new data.
- R9: Each read port serves its own address independently of the other read ports.
- R10: While a port's enable is low, its address and data inputs change no stored location.
- R11: A location keeps its value until it is written again. Writes to other addresses leave it intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears both banks |
| wr0En | input | 1 | Write enable of port 0 |
| wr0Addr | input | AW | Write address of port 0 |
| wr0Data | input | WIDTH | Write data of port 0 |
| wr1En | input | 1 | Write enable of port 1 |
| wr1Addr | input | AW | Write address of port 1 |
| wr1Data | input | WIDTH | Write data of port 1 |
| rdAddr | input | NUM_RD*AW | Read addresses; read port r uses bits [r*AW +: AW] |
| rdData | output | NUM_RD*WIDTH | Read data; read port r drives bits [r*WIDTH +: WIDTH] |

## Verification
A stale opposite-bank lookup corrupts the stored word. It does not show at the ports until a read reaches that address, which can be one cycle later or thousands. The fault shows as the XOR of the intended value and a previous value, not as an obvious error. For this reason, writes by one port and then the other to the same address are made in adjacent cycles and read back immediately. This exercises each bypass path. A long random phase then compares every read against a reference array, so that encoding damage hidden in one bank is caught when the address is visited again.

// File: rtl/xdw_pkg.sv
package xdw_pkg;
  // Strobes from control to datapath, indexed by write port.
  typedef struct packed {
    logic [1:0] commit;     // stage-1 write of this port lands in its bank now
    logic [1:0] lookupFwd;  // new lookup must take the opposite port's in-flight value
  } xdwStrobes_t;
endpackage

// File: rtl/xdw_bank.sv
module xdw_bank #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int NR    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [AW-1:0]            wAddr,
  input  logic [WIDTH-1:0]         wData,
  input  logic [NR-1:0][AW-1:0]    rAddr,
  output logic [NR-1:0][WIDTH-1:0] rVal
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wAddr] <= wData;
    end
  end

  always_comb begin
    for (int k = 0; k < NR; k++) rVal[k] = mem[rAddr[k]];
  end

  AST_BANK_STORE: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(wAddr)] == $past(wData)); // R11
endmodule

// File: rtl/xdw_ctrl.sv
module xdw_ctrl
  import xdw_pkg::*;
#(
  parameter int AW     = 4,
  parameter int NUM_RD = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  wrEn,
  input  logic [1:0][AW-1:0]          wrAddr,
  input  logic [NUM_RD-1:0][AW-1:0]   rdAddr,
  output xdwStrobes_t                 strobes,
  output logic [1:0][AW-1:0]          stgAddr,
  output logic [NUM_RD-1:0][1:0]      rdFwd
);
  logic [1:0] stgVld;

  always_ff @(posedge clk) begin
    if (rst) begin
      stgVld  <= '0;
      stgAddr <= '0;
    end else begin
      stgVld <= wrEn;
      for (int p = 0; p < 2; p++) begin
        if (wrEn[p]) stgAddr[p] <= wrAddr[p];
      end
    end
  end

  always_comb begin
    strobes.commit = stgVld;
    for (int p = 0; p < 2; p++) begin
      strobes.lookupFwd[p] = wrEn[p] && stgVld[1-p] && (wrAddr[p] == stgAddr[1-p]);
    end
    for (int r = 0; r < NUM_RD; r++) begin
      for (int b = 0; b < 2; b++) begin
        rdFwd[r][b] = stgVld[b] && (rdAddr[r] == stgAddr[b]);
      end
    end
  end
endmodule

// File: rtl/xdw_datapath.sv
module xdw_datapath
  import xdw_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter int NUM_RD = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  xdwStrobes_t                   strobes,
  input  logic [1:0][AW-1:0]            wrAddr,
  input  logic [1:0][WIDTH-1:0]         wrData,
  input  logic [1:0][AW-1:0]            stgAddr,
  input  logic [NUM_RD-1:0][AW-1:0]     rdAddr,
  input  logic [NUM_RD-1:0][1:0]        rdFwd,
  output logic [NUM_RD-1:0][WIDTH-1:0]  rdData
);
  localparam int NR = NUM_RD + 1;  // slot 0: opposite-port lookup, rest: external reads

  logic [1:0][WIDTH-1:0]         stgData;
  logic [1:0][WIDTH-1:0]         lookup;
  logic [1:0][WIDTH-1:0]         storeVal;
  logic [1:0][NR-1:0][AW-1:0]    bankAddr;
  logic [1:0][NR-1:0][WIDTH-1:0] bankRd;

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      bankAddr[b][0] = wrAddr[1-b];
      for (int r = 0; r < NUM_RD; r++) bankAddr[b][r+1] = rdAddr[r];
      storeVal[b] = stgData[b] ^ lookup[b];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : gen_bank
    xdw_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .NR(NR)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (strobes.commit[b]),
      .wAddr (stgAddr[b]),
      .wData (storeVal[b]),
      .rAddr (bankAddr[b]),
      .rVal  (bankRd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stgData <= '0;
      lookup  <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        stgData[p] <= wrData[p];
        lookup[p]  <= strobes.lookupFwd[p] ? storeVal[1-p] : bankRd[1-p][0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else begin
      for (int r = 0; r < NUM_RD; r++) begin
        rdData[r] <= (rdFwd[r][0] ? storeVal[0] : bankRd[0][r+1]) ^
                     (rdFwd[r][1] ? storeVal[1] : bankRd[1][r+1]);
      end
    end
  end

  AST_FWD_LOOKUP_VALUE: assert property (@(posedge clk) disable iff (rst)
    strobes.lookupFwd[0] |=> lookup[0] == $past(storeVal[1])); // R6
endmodule

// File: rtl/xor_dual_write_ram.sv
module xor_dual_write_ram
  import xdw_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int DEPTH  = 16,
  parameter int NUM_RD = 2,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr0En,
  input  logic [AW-1:0]             wr0Addr,
  input  logic [WIDTH-1:0]          wr0Data,
  input  logic                      wr1En,
  input  logic [AW-1:0]             wr1Addr,
  input  logic [WIDTH-1:0]          wr1Data,
  input  logic [NUM_RD*AW-1:0]      rdAddr,
  output logic [NUM_RD*WIDTH-1:0]   rdData
);
  logic [1:0]                      wrEn;
  logic [1:0][AW-1:0]              wrAddr;
  logic [1:0][WIDTH-1:0]           wrData;
  logic [NUM_RD-1:0][AW-1:0]       rdAddrV;
  logic [NUM_RD-1:0][WIDTH-1:0]    rdDataV;
  logic [NUM_RD-1:0][1:0]          rdFwd;
  logic [1:0][AW-1:0]              stgAddr;
  xdwStrobes_t                     strobes;

  assign wrEn    = {wr1En, wr0En};
  assign wrAddr  = {wr1Addr, wr0Addr};
  assign wrData  = {wr1Data, wr0Data};
  assign rdAddrV = rdAddr;
  assign rdData  = rdDataV;

  xdw_ctrl #(.AW(AW), .NUM_RD(NUM_RD)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddrV),
    .strobes (strobes),
    .stgAddr (stgAddr),
    .rdFwd   (rdFwd)
  );

  xdw_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .NUM_RD(NUM_RD)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .stgAddr (stgAddr),
    .rdAddr  (rdAddrV),
    .rdFwd   (rdFwd),
    .rdData  (rdDataV)
  );

  logic writesSeen;
  always_ff @(posedge clk) begin
    if (rst) writesSeen <= 1'b0;
    else if (|wrEn) writesSeen <= 1'b1;
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : gen_rd_chk
    AST_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
      !writesSeen |-> rdDataV[r] == '0); // R1
    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
      (!$past(|wrEn) && rdAddrV[r] == $past(rdAddrV[r])) |=> $stable(rdDataV[r])); // R11
  end

  AST_PORT0_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (wr0En && !(wr1En && wr1Addr == wr0Addr)) ##1 (rdAddrV[0] == $past(wr0Addr))
      |=> rdDataV[0] == $past(wr0Data, 2)); // R3
  AST_PORT1_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (wr1En && !(wr0En && wr0Addr == wr1Addr)) ##1 (rdAddrV[0] == $past(wr1Addr))
      |=> rdDataV[0] == $past(wr1Data, 2)); // R4
endmodule

// File: tb/xor_dual_write_ram_bench.sv
`timescale 1ns/1ps
module xor_dual_write_ram_bench;
  localparam int WIDTH  = 16;
  localparam int DEPTH  = 16;
  localparam int NUM_RD = 2;
  localparam int AW     = 4;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst;
  logic wr0En, wr1En;
  logic [AW-1:0] wr0Addr, wr1Addr;
  logic [WIDTH-1:0] wr0Data, wr1Data;
  logic [NUM_RD*AW-1:0] rdAddr;
  logic [NUM_RD*WIDTH-1:0] rdData;

  always #2.5 clk = ~clk;

  xor_dual_write_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NUM_RD(NUM_RD)) u_xor_dual_write_ram (
    .clk(clk), .rst(rst),
    .wr0En(wr0En), .wr0Addr(wr0Addr), .wr0Data(wr0Data),
    .wr1En(wr1En), .wr1Addr(wr1Addr), .wr1Data(wr1Data),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [WIDTH-1:0] refMem [DEPTH];
  logic [WIDTH-1:0] expQ [$];
  string tagQ [$];

  task automatic check(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; expected read values come from the
  // reference before this cycle's writes are applied.
  task automatic step(bit e0, int a0, logic [WIDTH-1:0] d0,
                      bit e1, int a1, logic [WIDTH-1:0] d1,
                      int r0, int r1, string tag);
    @(negedge clk);
    wr0En = e0; wr0Addr = AW'(a0); wr0Data = d0;
    wr1En = e1; wr1Addr = AW'(a1); wr1Data = d1;
    rdAddr = {AW'(r1), AW'(r0)};
    expQ.push_back(refMem[r0]); tagQ.push_back({tag, " rd0"});
    expQ.push_back(refMem[r1]); tagQ.push_back({tag, " rd1"});
    if (e0) refMem[a0] = d0;
    if (e1) refMem[a1] = d1;
  endtask

  // Monitor: results of the cycle before the last edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() >= NUM_RD) begin
        for (int r = 0; r < NUM_RD; r++) begin
          check(tagQ.pop_front(), rdData[r*WIDTH +: WIDTH], expQ.pop_front());
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    rst = 1'b1;
    wr0En = 0; wr1En = 0; wr0Addr = '0; wr1Addr = '0;
    wr0Data = '0; wr1Data = '0; rdAddr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 reset rd0", rdData[0 +: WIDTH], '0);
    check("R1 reset rd1", rdData[WIDTH +: WIDTH], '0);
    step(0, 0, 0, 0, 0, 0, 3, 15, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 9, "R1");
    // Port 0 then port 1 to one address on adjacent cycles.
    step(1, 5, 16'h1111, 0, 0, 0, 5, 5, "R7");
    step(0, 0, 0, 1, 5, 16'h2222, 5, 5, "R8");
    step(0, 0, 0, 0, 0, 0, 5, 5, "R6");
    // Disabled ports with live address and data.
    step(0, 5, 16'hDEAD, 0, 5, 16'hBEEF, 5, 0, "R10");
    step(0, 5, 16'h0BAD, 0, 5, 16'hF00D, 5, 5, "R10");
    step(0, 0, 0, 0, 0, 0, 5, 5, "R10");
    // Concurrent writes, distinct addresses.
    step(1, 2, 16'hA5A5, 1, 9, 16'h5A5A, 2, 9, "R5");
    step(0, 0, 0, 0, 0, 0, 2, 9, "R5");
    step(1, 7, 16'h0707, 0, 0, 0, 1, 1, "R3");
    step(0, 0, 0, 0, 0, 0, 7, 7, "R3");
    step(0, 0, 0, 1, 8, 16'h0808, 1, 1, "R4");
    step(0, 0, 0, 0, 0, 0, 8, 8, "R4");
    step(0, 0, 0, 0, 0, 0, 2, 7, "R9");
    step(0, 0, 0, 0, 0, 0, 8, 5, "R9");
    // Alternating ports on one address every cycle, read back each cycle.
    step(1, 11, 16'h0001, 0, 0, 0, 11, 11, "R6");
    step(0, 0, 0, 1, 11, 16'h0002, 11, 11, "R6");
    step(1, 11, 16'h0003, 0, 0, 0, 11, 11, "R6");
    step(0, 0, 0, 1, 11, 16'h0004, 11, 11, "R6");
    step(0, 0, 0, 0, 0, 0, 11, 2, "R6");
    // Changing address every cycle.
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 0, 0, i, DEPTH - 1 - i, "R2");
    // Random traffic against the reference.
    for (int n = 0; n < 3000; n++) begin
      int a0 = int'($urandom_range(DEPTH - 1));
      int a1 = int'($urandom_range(DEPTH - 1));
      bit e0 = 1'($urandom);
      bit e1 = 1'($urandom);
      if (e0 && e1 && a0 == a1) a1 = (a0 + 1) % DEPTH;
      step(e0, a0, WIDTH'($urandom), e1, a1, WIDTH'($urandom),
           int'($urandom_range(DEPTH - 1)), int'($urandom_range(DEPTH - 1)), "R11");
    end
    step(0, 0, 0, 0, 0, 0, 0, 1, "R11");
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule